// File: doc/BRIEF.md
# Upset-Tolerant One-Hot Control Sequencer

This block is a small control sequencer whose four-bit state register holds a one-hot code. Three states carry normal operation: an idle state, a run state and a done state. A start input moves the machine out of idle, and an advance input moves it through run and done and back to idle. A fourth state exists only to report faults. The block's users are control paths that must not lock up when a particle strike flips a state bit.

Every one of the sixteen possible register codes has a defined successor. Any code whose population count is not exactly one is decoded as corrupt. On the next clock the block steers it into the fault state and emits a single-cycle upset pulse. The fault state raises a level error output and holds until the surrounding logic acknowledges it, and the machine then returns to idle. A test-only override port loads an arbitrary code into the register, so that every corrupt pattern can be injected.

Top module: `seu_onehot_fsm`

## Requirements
- R1: A high `rst` sampled at a rising clock edge loads the idle code 4'b0001 and clears `upset_pulse`. Reset takes priority over the override port, the corrupt-code recovery and every transition.
- R2: In idle (4'b0001), a high `start` moves the state to run (4'b0010). Otherwise the state holds.
- R3: In run (4'b0010), a high `advance` moves the state to done (4'b0100). Otherwise the state holds.
- R4: In done (4'b0100), a high `advance` moves the state back to idle (4'b0001). Otherwise the state holds.
- R5: `err_flag` is high exactly while the state output equals the fault code 4'b1000.
- R6: In the fault state, the state holds while `ack` is low. When `ack` is high, the next edge returns the state to idle (4'b0001).
- R7: Any register code whose count of set bits is not one (4'b0000 and every code with two or more bits set) becomes the fault code 4'b1000 on the next edge. This happens whatever `start`, `advance` and `ack` are.
- R8: `upset_pulse` is high for the single cycle that follows an edge at which a corrupt code was held and neither `rst` nor `force_en` was high. It is low in every other cycle.
- R9: When `force_en` is high at an edge without reset, the register loads `force_code` unchanged, and `upset_pulse` is low in the following cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Leave idle for run |
| advance | input | 1 | Step run to done, and done to idle |
| ack | input | 1 | Acknowledge a reported fault |
| force_en | input | 1 | Test override: load `force_code` into the state register |
| force_code | input | 4 | Code loaded by the override |
| state | output | 4 | Current state register contents |
| err_flag | output | 1 | High while in the fault state |
| upset_pulse | output | 1 | One-cycle marker of a detected corrupt code |

## Verification
Each state change and each upset pulse is due in the cycle right after the edge that samples the inputs. `err_flag` follows the state register with no extra delay. The bench drives inputs just after a falling edge and samples all three outputs at the next falling edge. Its reference model is advanced once per step, so every expected value lines up with exactly one register stage. Injected corrupt codes take two steps: the override load, then the recovery edge. Both steps are compared this way, and so is the step after them, where the pulse must have dropped.

// File: rtl/seu_onehot_fsm.sv
module seu_onehot_fsm (
  input  logic       clk,
  input  logic       rst,
  input  logic       start,
  input  logic       advance,
  input  logic       ack,
  input  logic       force_en,
  input  logic [3:0] force_code,
  output logic [3:0] state,
  output logic       err_flag,
  output logic       upset_pulse
);

  localparam logic [3:0] ST_IDLE = 4'b0001;
  localparam logic [3:0] ST_RUN  = 4'b0010;
  localparam logic [3:0] ST_DONE = 4'b0100;
  localparam logic [3:0] ST_ERR  = 4'b1000;

  logic [3:0] state_q, state_d;
  logic [2:0] ones;
  logic       code_bad;
  logic       upset_q;

  assign ones = {2'b00, state_q[0]} + {2'b00, state_q[1]}
              + {2'b00, state_q[2]} + {2'b00, state_q[3]};
  assign code_bad = (ones != 3'd1);

  always_comb begin
    state_d = ST_ERR;
    if (!code_bad) begin
      case (state_q)
        ST_IDLE: state_d = start   ? ST_RUN  : ST_IDLE;
        ST_RUN:  state_d = advance ? ST_DONE : ST_RUN;
        ST_DONE: state_d = advance ? ST_IDLE : ST_DONE;
        ST_ERR:  state_d = ack     ? ST_IDLE : ST_ERR;
        default: state_d = ST_ERR;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      upset_q <= 1'b0;
    end else if (force_en) begin
      state_q <= force_code;
      upset_q <= 1'b0;
    end else begin
      state_q <= state_d;
      upset_q <= code_bad;
    end
  end

  assign state       = state_q;
  assign err_flag    = (state_q == ST_ERR);
  assign upset_pulse = upset_q;

  p_reset_idle_r1: assert property (@(posedge clk)
    rst |=> (state == ST_IDLE && !upset_pulse));

  p_idle_start_r2: assert property (@(posedge clk) disable iff (rst)
    (state == ST_IDLE && start && !force_en) |=> state == ST_RUN);

  p_run_hold_r3: assert property (@(posedge clk) disable iff (rst)
    (state == ST_RUN && !advance && !force_en) |=> state == ST_RUN);

  p_done_wrap_r4: assert property (@(posedge clk) disable iff (rst)
    (state == ST_DONE && advance && !force_en) |=> state == ST_IDLE);

  p_err_hold_r6: assert property (@(posedge clk) disable iff (rst)
    (state == ST_ERR && !ack && !force_en) |=> err_flag);

  p_err_ack_r6: assert property (@(posedge clk) disable iff (rst)
    (state == ST_ERR && ack && !force_en) |=> state == ST_IDLE);

  p_bad_to_err_r7: assert property (@(posedge clk) disable iff (rst)
    ($countones(state) != 1 && !force_en) |=> (state == ST_ERR && upset_pulse));

  p_legal_after_step_r7: assert property (@(posedge clk) disable iff (rst)
    !force_en |=> $countones(state) == 1);

  p_pulse_single_r8: assert property (@(posedge clk) disable iff (rst)
    (upset_pulse && !force_en) |=> !upset_pulse);

  p_pulse_in_err_r8: assert property (@(posedge clk) disable iff (rst)
    upset_pulse |-> err_flag);

  p_force_load_r9: assert property (@(posedge clk) disable iff (rst)
    force_en |=> (state == $past(force_code) && !upset_pulse));

endmodule

// File: tb/test_seu_onehot_fsm.sv
module test_seu_onehot_fsm;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       start = 1'b0, advance = 1'b0, ack = 1'b0, force_en = 1'b0;
  logic [3:0] force_code = 4'b0000;
  logic [3:0] state;
  logic       err_flag, upset_pulse;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;
  logic [3:0] ref_state;
  logic       ref_up;

  always #10 clk = ~clk;

  seu_onehot_fsm i_seu_onehot_fsm (
    .clk(clk), .rst(rst), .start(start), .advance(advance), .ack(ack),
    .force_en(force_en), .force_code(force_code),
    .state(state), .err_flag(err_flag), .upset_pulse(upset_pulse)
  );

  function automatic int pop4(input logic [3:0] v);
    return int'(v[0]) + int'(v[1]) + int'(v[2]) + int'(v[3]);
  endfunction

  function automatic logic [3:0] model_next(input logic [3:0] s, input logic r,
      input logic fe, input logic [3:0] fc, input logic st, input logic ad, input logic ak);
    if (r) return 4'b0001;
    if (fe) return fc;
    if (pop4(s) != 1) return 4'b1000;
    case (s)
      4'b0001: return st ? 4'b0010 : 4'b0001;
      4'b0010: return ad ? 4'b0100 : 4'b0010;
      4'b0100: return ad ? 4'b0001 : 4'b0100;
      default: return ak ? 4'b0001 : 4'b1000;
    endcase
  endfunction

  function automatic string tag_of(input logic [3:0] s, input logic r, input logic fe);
    if (r) return "R1";
    if (fe) return "R9";
    if (pop4(s) != 1) return "R7";
    case (s)
      4'b0001: return "R2";
      4'b0010: return "R3";
      4'b0100: return "R4";
      default: return "R6";
    endcase
  endfunction

  task automatic check(input string req, input logic [3:0] act, input logic [3:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%b expected=%b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic step(input logic r, input logic fe, input logic [3:0] fc,
                      input logic st, input logic ad, input logic ak);
    string t;
    logic [3:0] nxt;
    logic nup;
    t   = tag_of(ref_state, r, fe);
    nxt = model_next(ref_state, r, fe, fc, st, ad, ak);
    nup = !r && !fe && (pop4(ref_state) != 1);
    rst = r; force_en = fe; force_code = fc; start = st; advance = ad; ack = ak;
    @(negedge clk);
    ref_state = nxt;
    ref_up    = nup;
    check(t, state, ref_state);
    check("R5", {3'b000, err_flag}, {3'b000, ref_state == 4'b1000});
    check("R8", {3'b000, upset_pulse}, {3'b000, ref_up});
  endtask

  initial begin
    #(20 * 150000);
    failures++;
    $display("FAIL watchdog actual=running expected=done");
    if (!finished) $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int unsigned seed_dummy;
    seed_dummy = $urandom(32'h5EED_0042);
    ref_state = 4'b0001;
    ref_up = 1'b0;
    @(negedge clk);
    step(1'b1, 1'b0, 4'b0, 1'b0, 1'b0, 1'b0);
    step(1'b1, 1'b1, 4'b0110, 1'b1, 1'b1, 1'b1);

    // R2, R3, R4 directed hold and walk
    step(1'b0, 1'b0, 4'b0, 1'b0, 1'b1, 1'b1);
    step(1'b0, 1'b0, 4'b0, 1'b1, 1'b0, 1'b0);
    step(1'b0, 1'b0, 4'b0, 1'b1, 1'b0, 1'b1);
    step(1'b0, 1'b0, 4'b0, 1'b0, 1'b1, 1'b0);
    step(1'b0, 1'b0, 4'b0, 1'b1, 1'b0, 1'b1);
    step(1'b0, 1'b0, 4'b0, 1'b0, 1'b1, 1'b0);

    // R7, R8, R9: inject all sixteen codes, recovery inputs all high
    for (int c = 0; c < 16; c++) begin
      step(1'b0, 1'b1, 4'(c), 1'b0, 1'b0, 1'b0);
      step(1'b0, 1'b0, 4'b0, 1'b1, 1'b1, 1'b1);
      step(1'b0, 1'b0, 4'b0, 1'b0, 1'b0, 1'b0);
      step(1'b0, 1'b0, 4'b0, 1'b0, 1'b0, 1'b1);
    end

    // R6: fault held without ack, then released
    step(1'b0, 1'b1, 4'b0000, 1'b0, 1'b0, 1'b0);
    step(1'b0, 1'b0, 4'b0, 1'b0, 1'b0, 1'b0);
    step(1'b0, 1'b0, 4'b0, 1'b1, 1'b1, 1'b0);
    step(1'b0, 1'b0, 4'b0, 1'b0, 1'b0, 1'b1);

    // R1: reset beats recovery of a corrupt code
    step(1'b0, 1'b1, 4'b0101, 1'b0, 1'b0, 1'b0);
    step(1'b1, 1'b0, 4'b0, 1'b1, 1'b1, 1'b1);

    // constrained random
    for (int i = 0; i < 3000; i++) begin
      logic r, fe;
      r  = ($urandom_range(0, 99) < 3);
      fe = ($urandom_range(0, 99) < 8);
      step(r, fe, 4'($urandom_range(0, 15)), 1'($urandom), 1'($urandom), 1'($urandom));
    end

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule